// File: doc/BRIEF.md
# Zero-Skipping Bit-Serial Convolution Engine

This engine forms one convolution output as a dot product over every kernel position and input channel. It handles the weights one bit per cycle instead of using a parallel multiplier. Each weight and activation pair is held in an entry whose flat index is `kpos*NCH + ch`. While weights are written, a per-entry nonzero flag is recorded. On each cycle the engine ANDs one weight bit with the activation of the selected entry and adds the result to an accumulator. The most significant bit is taken first. At the start of each new bit pass the accumulator is doubled, so every bit enters at its proper significance. Partial sums from all kernel positions meet in the same accumulator.

The weight precision is chosen for each run. Entries whose stored weight is zero are never visited, so a run costs `prec * nonzero_entries` issue cycles plus two pipeline cycles. The memory read of the next entry overlaps the accumulation of the current one. Software loads weights and activations while the engine is idle, pulses `start`, and collects `result` in the cycle where `done` pulses.

Top module: `zsbs_conv_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `result` are all 0.
- R2: `result` equals the sum, over all entries, of `(w mod 2^p) * a`. Here `w` is the 16-bit unsigned stored weight, `a` is the 8-bit unsigned activation (the low 8 bits of `ld_data` when `ld_is_act`=1), and `p` is the effective precision.
- R3: The accumulator is wide enough that all 72 entries at weight 0xFFFF and activation 0xFF, with p=16, give the exact sum without overflow.
- R4: `done` rises exactly `p*N + 2` clock edges after the edge that samples `start`. N is the number of entries with a nonzero stored weight. Zero-weight entries add no cycles.
- R5: When every stored weight is zero, `done` rises 2 edges after start and `result` is 0.
- R6: `done` is a one-cycle pulse. `busy` is high from the edge after an accepted start up to the cycle in which `done` is high, where it is low.
- R7: A `start` pulse while `busy` is high is ignored. No extra run begins and no extra `done` appears.
- R8: Loads while `busy` is high are ignored. Later runs still use the earlier contents.
- R9: `prec` is sampled at start and clamped: 0 acts as 1, and values above 16 act as 16. Weight bits at position `p` and above do not change `result`, but such an entry still counts toward N.
- R10: `result` holds its value except in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe |
| ld_is_act | input | 1 | 1 = activation write, 0 = weight write |
| ld_idx | input | 7 | Entry index, kpos*NCH + ch |
| ld_data | input | 16 | Weight, or activation in bits 7:0 |
| prec | input | 5 | Weight precision for the next run |
| start | input | 1 | Start request, taken only while idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse; result valid |
| result | output | 32 | Dot product of the last run |

## Verification
A fault in the nonzero flags or the channel picker shows up in two ways: `done` arrives a whole number of bit passes early or late, and the value differs by the products of the entries that were missed or repeated. A fault in the bit counter or the doubling step scales or shears the sum. Random weights make such a fault visible in the first run where it occurs. Faults in the control path show at the handshake within a few cycles: a start or load taken while busy appears as a second `done`, or as a changed result on the next rerun.

// File: rtl/zsbs_pkg.sv
package zsbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } seq_st_e;
endpackage

// File: rtl/zsbs_store.sv
module zsbs_store #(
  parameter int NENT  = 72,
  parameter int WMAX  = 16,
  parameter int ACT_W = 8,
  localparam int IW   = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             is_act,
  input  logic [IW-1:0]    widx,
  input  logic [WMAX-1:0]  wdata,
  input  logic             rd_en,
  input  logic [IW-1:0]    rd_idx,
  output logic [WMAX-1:0]  rd_wt,
  output logic [ACT_W-1:0] rd_act,
  output logic [NENT-1:0]  mask
);
  logic [WMAX-1:0]  wmem [NENT];
  logic [ACT_W-1:0] amem [NENT];

  // Block-RAM style: write port plus registered read, no reset on the arrays
  always_ff @(posedge clk) begin
    if (we && !is_act) wmem[widx] <= wdata;
    if (we && is_act)  amem[widx] <= wdata[ACT_W-1:0];
    if (rd_en) begin
      rd_wt  <= wmem[rd_idx];
      rd_act <= amem[rd_idx];
    end
  end

  // Nonzero flag per entry, captured when the weight is written
  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else if (we && !is_act) mask[widx] <= (wdata != '0);
  end
endmodule

// File: rtl/zsbs_pick.sv
module zsbs_pick #(
  parameter int NENT = 72,
  localparam int IW  = $clog2(NENT)
) (
  input  logic [NENT-1:0] vec,
  output logic            found,
  output logic [IW-1:0]   idx,
  output logic            last
);
  // Lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign found = |vec;
  assign last  = found && ((vec & (vec - NENT'(1))) == '0);
endmodule

// File: rtl/zsbs_seq.sv
module zsbs_seq
  import zsbs_pkg::*;
#(
  parameter int NENT = 72,
  parameter int WMAX = 16,
  localparam int IW  = $clog2(NENT),
  localparam int PW  = $clog2(WMAX + 1),
  localparam int BW  = $clog2(WMAX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [PW-1:0]   prec,
  input  logic [NENT-1:0] mask,
  output logic            busy,
  output logic            acc_clr,
  output logic            rd_en,
  output logic [IW-1:0]   rd_idx,
  output logic            m_v,
  output logic [BW-1:0]   m_bit,
  output logic            m_first,
  output logic            fin
);
  seq_st_e         st;
  logic [NENT-1:0] rem;
  logic [BW-1:0]   bitq;
  logic            firstq;
  logic [PW-1:0]   p_eff;
  logic            pk_found, pk_last;
  logic [IW-1:0]   pk_idx;

  zsbs_pick #(.NENT(NENT)) u_pick (
    .vec(rem), .found(pk_found), .idx(pk_idx), .last(pk_last)
  );

  always_comb begin
    if (prec == '0)                p_eff = PW'(1);
    else if (32'(prec) > WMAX)     p_eff = PW'(WMAX);
    else                           p_eff = prec;
  end

  assign busy    = (st != ST_IDLE);
  assign acc_clr = (st == ST_IDLE) && start;
  assign rd_en   = (st == ST_RUN) && pk_found;
  assign rd_idx  = pk_idx;
  assign fin     = (st == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      rem     <= '0;
      bitq    <= '0;
      firstq  <= 1'b0;
      m_v     <= 1'b0;
      m_bit   <= '0;
      m_first <= 1'b0;
    end else begin
      m_v     <= rd_en;
      m_bit   <= bitq;
      m_first <= firstq;
      case (st)
        ST_IDLE: if (start) begin
          bitq   <= BW'(p_eff - PW'(1));
          rem    <= mask;
          firstq <= 1'b1;
          st     <= (|mask) ? ST_RUN : ST_DRAIN;
        end
        ST_RUN: begin
          if (pk_last) begin
            if (bitq == '0) begin
              rem <= '0;
              st  <= ST_DRAIN;
            end else begin
              bitq   <= bitq - BW'(1);
              rem    <= mask;
              firstq <= 1'b1;
            end
          end else begin
            rem[pk_idx] <= 1'b0;
            firstq      <= 1'b0;
          end
        end
        ST_DRAIN: st <= ST_FIN;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/zsbs_acc.sv
module zsbs_acc #(
  parameter int WMAX  = 16,
  parameter int ACT_W = 8,
  parameter int ACC_W = 32,
  localparam int BW   = $clog2(WMAX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             v,
  input  logic             first,
  input  logic [BW-1:0]    bsel,
  input  logic [WMAX-1:0]  wt,
  input  logic [ACT_W-1:0] act,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] term;

  assign term = wt[bsel] ? ACC_W'(act) : '0;

  // Horner step: double on the first entry of each bit pass
  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (v)     acc <= (first ? (acc << 1) : acc) + term;
  end
endmodule

// File: rtl/zsbs_conv_engine.sv
module zsbs_conv_engine #(
  parameter int NCH   = 8,
  parameter int NKER  = 9,
  parameter int ACT_W = 8,
  parameter int WMAX  = 16,
  localparam int NENT  = NCH * NKER,
  localparam int IW    = $clog2(NENT),
  localparam int PW    = $clog2(WMAX + 1),
  localparam int BW    = $clog2(WMAX),
  localparam int ACC_W = WMAX + ACT_W + $clog2(NENT) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic             ld_is_act,
  input  logic [IW-1:0]    ld_idx,
  input  logic [WMAX-1:0]  ld_data,
  input  logic [PW-1:0]    prec,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [ACC_W-1:0] result
);
  logic             we, acc_clr, rd_en, m_v, m_first, fin;
  logic [IW-1:0]    rd_idx;
  logic [BW-1:0]    m_bit;
  logic [WMAX-1:0]  rd_wt;
  logic [ACT_W-1:0] rd_act;
  logic [NENT-1:0]  mask;
  logic [ACC_W-1:0] acc;

  assign we = ld_en && !busy && (32'(ld_idx) < NENT);

  zsbs_store #(.NENT(NENT), .WMAX(WMAX), .ACT_W(ACT_W)) u_store (
    .clk(clk), .rst(rst), .we(we), .is_act(ld_is_act), .widx(ld_idx),
    .wdata(ld_data), .rd_en(rd_en), .rd_idx(rd_idx), .rd_wt(rd_wt),
    .rd_act(rd_act), .mask(mask)
  );

  zsbs_seq #(.NENT(NENT), .WMAX(WMAX)) u_seq (
    .clk(clk), .rst(rst), .start(start), .prec(prec), .mask(mask),
    .busy(busy), .acc_clr(acc_clr), .rd_en(rd_en), .rd_idx(rd_idx),
    .m_v(m_v), .m_bit(m_bit), .m_first(m_first), .fin(fin)
  );

  zsbs_acc #(.WMAX(WMAX), .ACT_W(ACT_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .v(m_v), .first(m_first),
    .bsel(m_bit), .wt(rd_wt), .act(rd_act), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= fin;
      if (fin) result <= acc;
    end
  end
endmodule

// File: rtl/zsbs_conv_chk.sv
module zsbs_conv_chk #(
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [RW-1:0] result
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_start_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_done_after_run_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

bind zsbs_conv_engine zsbs_conv_chk #(.RW(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .result(result)
);

// File: tb/tb_zsbs_conv_engine.sv
module tb_zsbs_conv_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 8;
  localparam int NKER = 9;
  localparam int NENT = NCH * NKER;
  localparam int IW   = $clog2(NENT);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0, ld_is_act = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [15:0] ld_data = '0;
  logic [4:0]  prec = 5'd1;
  logic        start = 1'b0;
  logic        busy, done;
  logic [31:0] result;

  int n_chk = 0, n_bad = 0;
  int unsigned w_m [NENT];
  int unsigned a_m [NENT];

  zsbs_conv_engine #(.NCH(NCH), .NKER(NKER)) dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_is_act(ld_is_act),
    .ld_idx(ld_idx), .ld_data(ld_data), .prec(prec), .start(start),
    .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_p(input int p);
    return (p == 0) ? 1 : ((p > 16) ? 16 : p);
  endfunction

  function automatic longint exp_val(input int p);
    longint s = 0;
    int pe = eff_p(p);
    for (int i = 0; i < NENT; i++)
      s += longint'(w_m[i] & ((32'd1 << pe) - 1)) * longint'(a_m[i]);
    return s;
  endfunction

  function automatic int exp_cyc(input int p);
    int n = 0;
    for (int i = 0; i < NENT; i++) if (w_m[i] != 0) n++;
    return eff_p(p) * n + 2;
  endfunction

  task automatic load(input bit is_act, input int idx, input int unsigned val);
    @(negedge clk);
    ld_en = 1'b1; ld_is_act = is_act; ld_idx = IW'(idx); ld_data = 16'(val);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic put(input int idx, input int unsigned w, input int unsigned a);
    load(1'b0, idx, w); w_m[idx] = w & 16'hFFFF;
    load(1'b1, idx, a); a_m[idx] = a & 8'hFF;
  endtask

  // mode 0: plain, 1: start while busy, 2: load while busy
  task automatic run(input int p, input int mode, input string tag);
    int cyc = 0;
    longint ev = exp_val(p);
    int ec = exp_cyc(p);
    @(negedge clk);
    prec = 5'(p); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 5000) begin
      if (cyc == 2 && mode == 1) start = 1'b1;
      if (cyc == 2 && mode == 2) begin
        ld_en = 1'b1; ld_is_act = 1'b0; ld_idx = '0; ld_data = 16'hFFFF;
      end
      @(posedge clk); cyc++;
      @(negedge clk);
      start = 1'b0; ld_en = 1'b0;
    end
    chk({"R4 cycles ", tag}, cyc, ec);
    chk({"R2 value ", tag}, result, ev);
    chk({"R6 busy low at done ", tag}, busy, 0);
    @(negedge clk);
    chk({"R6 done pulse ", tag}, done, 0);
    if (mode == 1) begin
      for (int k = 0; k < ec + 4; k++) begin
        @(negedge clk);
        if (done || busy) begin chk("R7 no extra run", 1, 0); break; end
      end
      chk("R7 idle after ignored start", busy, 0);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < NENT; i++) put(i, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk("watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    longint held;
    void'($urandom(32'd2024));
    for (int i = 0; i < NENT; i++) begin w_m[i] = 0; a_m[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 result", result, 0);
    rst = 1'b0;

    clear_all();
    run(8, 0, "all-zero R5");
    chk("R5 zero result", result, 0);

    put(5, 1, 200);
    run(1, 0, "single p1");

    put(17, 16'h00F3, 77); put(70, 16'h8001, 255);
    run(16, 0, "sparse p16");

    // R9 clamp and ignored high bits
    run(0, 0, "R9 p0");
    run(20, 0, "R9 p20");
    run(4, 0, "R9 p4 high bits");

    // R7 and R8
    run(16, 1, "R7 start busy");
    run(16, 2, "R8 load busy");
    held = result;
    run(16, 0, "R8 rerun");
    chk("R8 result unchanged", result, held);

    // R10 hold while idle
    repeat (5) @(negedge clk);
    chk("R10 hold", result, held);

    // random
    for (int t = 0; t < 8; t++) begin
      for (int i = 0; i < NENT; i++)
        put(i, ($urandom % 3 == 0) ? ($urandom % 65536) : 0, $urandom % 256);
      run(1 + ($urandom % 16), 0, "random");
    end

    // R3 maximum
    for (int i = 0; i < NENT; i++) put(i, 16'hFFFF, 8'hFF);
    run(16, 0, "R3 max");
    chk("R3 full sum", result, longint'(65535) * 255 * NENT);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule